// File: doc/BRIEF.md
# Wavefront Lane-Mask Divergence Controller

This block keeps the per-lane activity state for one wide wavefront. The wavefront runs on a narrower vector datapath. It holds an execute mask with one bit per lane and a condition mask that vector compares fill. It also holds a small file of saved masks. Divergent if/else code is handled entirely by scalar mask operations, with no reconvergence stack. The sequence is as follows:

1. Save the current execute mask.
2. Narrow the execute mask to the lanes whose condition passed.
3. Later, switch to the saved lanes that were not on the taken path.
4. Restore the saved mask at the join point.

Two zero flags, one for the execute mask and one for the condition mask, let the front end skip a body in which no lane would run.

A vector instruction is issued as a sequence of narrow passes. On each pass the block drives the matching slice of the execute mask as write enables toward the vector register file. When the instruction is a compare, it captures that slice of compare results into the condition mask. Instruction decode and the program counter stay outside. The front end receives only a taken/not-taken answer for the two skip-branch kinds.

Top module: `lane_mask_ctrl`

## Requirements
- R1: After reset the execute mask is all ones, the condition mask is all zeros, every saved-mask entry is zero, no pass is active and all write enables are 0.
- R2: A save operation (`sop_kind` 0) copies the execute mask into saved entry `sop_sreg` and leaves the execute mask unchanged.
- R3: An and-condition operation (`sop_kind` 1) sets the execute mask to the condition mask ANDed with the current execute mask.
- R4: An and-not operation (`sop_kind` 2) sets the execute mask to saved entry `sop_sreg` ANDed with the inverse of the current execute mask.
- R5: A restore operation (`sop_kind` 3) sets the execute mask to saved entry `sop_sreg`.
- R6: A `vec_start` accepted while idle produces four consecutive pass cycles, starting in the next cycle, with `pass_idx` 0, 1, 2, 3. Pass p covers lanes 16p to 16p+15, and `pass_last` is high only on pass 3.
- R7: During pass p, `lane_wen` bit j equals execute-mask bit 16p+j. Outside a pass, `lane_wen` is all zeros.
- R8: On a compare instruction, pass p writes condition-mask bits 16p..16p+15 with `cmp_result` ANDed with the execute slice, so an inactive lane's bit becomes 0. A non-compare instruction leaves the condition mask unchanged.
- R9: `vccz` and `execz` are high exactly when the registered condition or execute mask is all zeros, and they reflect an update from the cycle before. `br_taken` equals `br_valid` AND the zero flag selected by `br_kind` (0 selects `vccz`, 1 selects `execz`).
- R10: While a pass is active, `vec_start` and scalar mask operations are ignored: the pass sequence continues unchanged and the execute mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sop_valid | input | 1 | Scalar mask operation request |
| sop_kind | input | 2 | 0 save, 1 and-condition, 2 and-not saved, 3 restore |
| sop_sreg | input | 3 | Saved-mask entry index |
| vec_start | input | 1 | Start a four-pass vector instruction |
| vec_is_cmp | input | 1 | The started instruction is a compare |
| cmp_result | input | 16 | Compare results for the lanes of the current pass |
| br_valid | input | 1 | Skip-branch query |
| br_kind | input | 1 | 0 tests condition-mask zero, 1 tests execute-mask zero |
| br_taken | output | 1 | Branch taken |
| pass_active | output | 1 | A vector pass is in progress |
| pass_idx | output | 2 | Current pass number |
| pass_last | output | 1 | Current pass is the final one |
| lane_wen | output | 16 | Per-lane write enables for the current pass |
| exec_mask | output | 64 | Execute mask |
| vcc_mask | output | 64 | Condition mask |
| execz | output | 1 | Execute mask is all zeros |
| vccz | output | 1 | Condition mask is all zeros |

## Verification
The assertions assume that the front end does not overlap work: a scalar operation or a new vector instruction arrives only while no pass runs. The one exception is the deliberate intrusion that R10 describes. They also assume that `cmp_result` is meaningful only during compare passes. The stimulus drives every request for a single cycle from an idle state. It injects an overlapping restore and restart only in selected middle passes, and it checks that these have no effect. Mask patterns come from a multiplicative hash over a sweep of seeds, with all-zero and all-one cases among them, and nested if/else sequences reuse different saved entries.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [1:0] {
    SOP_SAVE       = 2'd0,
    SOP_AND_VCC    = 2'd1,
    SOP_ANDN_SAVED = 2'd2,
    SOP_RESTORE    = 2'd3
  } sop_e;
endpackage

// File: rtl/lmc_pass_seq.sv
module lmc_pass_seq #(
  parameter int NUM_PASSES = 4,
  localparam int IDX_W = (NUM_PASSES > 1) ? $clog2(NUM_PASSES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_cmp,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             last,
  output logic             is_cmp
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PASSES - 1);

  logic             active_d;
  logic [IDX_W-1:0] idx_d;
  logic             cmp_d;
  logic             seq_en;

  assign last = active && (idx == LAST_IDX);

  always_comb begin
    active_d = active;
    idx_d    = idx;
    cmp_d    = is_cmp;
    seq_en   = 1'b0;
    if (active) begin
      seq_en = 1'b1;
      if (last) begin
        active_d = 1'b0;
        idx_d    = '0;
        cmp_d    = 1'b0;
      end else begin
        idx_d = idx + IDX_W'(1);
      end
    end else if (start) begin
      seq_en   = 1'b1;
      active_d = 1'b1;
      idx_d    = '0;
      cmp_d    = start_cmp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      is_cmp <= 1'b0;
    end else if (seq_en) begin
      active <= active_d;
      idx    <= idx_d;
      is_cmp <= cmp_d;
    end
  end
endmodule

// File: rtl/lmc_mask_regs.sv
module lmc_mask_regs
  import lmc_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int PASS_W = 16,
  parameter int DEPTH  = 8,
  localparam int NUM_PASSES = LANES / PASS_W,
  localparam int IDX_W  = (NUM_PASSES > 1) ? $clog2(NUM_PASSES) : 1,
  localparam int SIDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop_fire,
  input  sop_e              sop_kind,
  input  logic [SIDX_W-1:0] sop_idx,
  input  logic              cmp_fire,
  input  logic [IDX_W-1:0]  cmp_slice,
  input  logic [PASS_W-1:0] cmp_bits,
  output logic [LANES-1:0]  exec_q,
  output logic [LANES-1:0]  vcc_q
);
  logic [LANES-1:0] sreg_q [DEPTH];
  logic [LANES-1:0] exec_d;
  logic [LANES-1:0] vcc_d;
  logic [LANES-1:0] saved_rd;
  logic             exec_en;
  logic             sreg_en;

  assign saved_rd = sreg_q[sop_idx];

  always_comb begin
    exec_d  = exec_q;
    exec_en = 1'b0;
    sreg_en = 1'b0;
    if (sop_fire) begin
      unique case (sop_kind)
        SOP_SAVE:       sreg_en = 1'b1;
        SOP_AND_VCC:    begin exec_en = 1'b1; exec_d = vcc_q & exec_q;     end
        SOP_ANDN_SAVED: begin exec_en = 1'b1; exec_d = saved_rd & ~exec_q; end
        SOP_RESTORE:    begin exec_en = 1'b1; exec_d = saved_rd;           end
        default:        ;
      endcase
    end
  end

  always_comb begin
    vcc_d = vcc_q;
    for (int s = 0; s < NUM_PASSES; s++) begin
      if (cmp_fire && (cmp_slice == IDX_W'(s))) begin
        vcc_d[s*PASS_W +: PASS_W] = cmp_bits & exec_q[s*PASS_W +: PASS_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q <= '1;
    end else if (exec_en) begin
      exec_q <= exec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcc_q <= '0;
    end else if (cmp_fire) begin
      vcc_q <= vcc_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_sreg
    logic wr_en;
    assign wr_en = sreg_en && (sop_idx == SIDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sreg_q[e] <= '0;
      end else if (wr_en) begin
        sreg_q[e] <= exec_q;
      end
    end
  end
endmodule

// File: rtl/lmc_zero_detect.sv
module lmc_zero_detect #(
  parameter int WIDTH = 64,
  parameter int CHUNK = 16,
  localparam int NCH = WIDTH / CHUNK
) (
  input  logic [WIDTH-1:0] vec,
  output logic             is_zero
);
  logic [NCH-1:0] chunk_any;

  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    assign chunk_any[c] = |vec[c*CHUNK +: CHUNK];
  end

  assign is_zero = ~|chunk_any;
endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl
  import lmc_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int PASS_W = 16,
  parameter int DEPTH  = 8,
  localparam int NUM_PASSES = LANES / PASS_W,
  localparam int IDX_W  = (NUM_PASSES > 1) ? $clog2(NUM_PASSES) : 1,
  localparam int SIDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop_valid,
  input  logic [1:0]        sop_kind,
  input  logic [SIDX_W-1:0] sop_sreg,
  input  logic              vec_start,
  input  logic              vec_is_cmp,
  input  logic [PASS_W-1:0] cmp_result,
  input  logic              br_valid,
  input  logic              br_kind,
  output logic              br_taken,
  output logic              pass_active,
  output logic [IDX_W-1:0]  pass_idx,
  output logic              pass_last,
  output logic [PASS_W-1:0] lane_wen,
  output logic [LANES-1:0]  exec_mask,
  output logic [LANES-1:0]  vcc_mask,
  output logic              execz,
  output logic              vccz
);
  logic rst_meta_q, rst_int_n;
  logic seq_is_cmp;
  logic sop_fire;
  logic cmp_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  assign sop_fire = sop_valid && !pass_active;
  assign cmp_fire = pass_active && seq_is_cmp;

  lmc_pass_seq #(.NUM_PASSES(NUM_PASSES)) seq_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (vec_start),
    .start_cmp (vec_is_cmp),
    .active    (pass_active),
    .idx       (pass_idx),
    .last      (pass_last),
    .is_cmp    (seq_is_cmp)
  );

  lmc_mask_regs #(.LANES(LANES), .PASS_W(PASS_W), .DEPTH(DEPTH)) regs_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sop_fire  (sop_fire),
    .sop_kind  (sop_e'(sop_kind)),
    .sop_idx   (sop_sreg),
    .cmp_fire  (cmp_fire),
    .cmp_slice (pass_idx),
    .cmp_bits  (cmp_result),
    .exec_q    (exec_mask),
    .vcc_q     (vcc_mask)
  );

  lmc_zero_detect #(.WIDTH(LANES), .CHUNK(PASS_W)) exz_i (
    .vec     (exec_mask),
    .is_zero (execz)
  );

  lmc_zero_detect #(.WIDTH(LANES), .CHUNK(PASS_W)) vcz_i (
    .vec     (vcc_mask),
    .is_zero (vccz)
  );

  assign lane_wen = pass_active ? exec_mask[pass_idx*PASS_W +: PASS_W] : '0;
  assign br_taken = br_valid && (br_kind ? execz : vccz);
endmodule

// File: rtl/lmc_checker.sv
module lmc_checker #(
  parameter int LANES  = 64,
  parameter int PASS_W = 16,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              pass_active,
  input logic [IDX_W-1:0]  pass_idx,
  input logic              pass_last,
  input logic [PASS_W-1:0] lane_wen,
  input logic [LANES-1:0]  exec_mask,
  input logic [LANES-1:0]  vcc_mask,
  input logic              execz,
  input logic              sop_valid,
  input logic              seq_is_cmp
);
  logic              prev_cmp_q;
  logic [IDX_W-1:0]  prev_idx_q;
  logic [PASS_W-1:0] prev_wen_q;
  logic [PASS_W-1:0] vcc_slice;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      prev_cmp_q <= 1'b0;
      prev_idx_q <= '0;
      prev_wen_q <= '0;
    end else begin
      prev_cmp_q <= pass_active && seq_is_cmp;
      prev_idx_q <= pass_idx;
      prev_wen_q <= lane_wen;
    end
  end

  assign vcc_slice = vcc_mask[prev_idx_q*PASS_W +: PASS_W];

  assert_pass_advance_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pass_active && !pass_last) |=> (pass_active && pass_idx == $past(pass_idx) + IDX_W'(1)));

  assert_pass_end_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    pass_last |=> !pass_active);

  assert_idle_wen_zero_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pass_active |-> (lane_wen == '0));

  assert_inactive_vcc_clear_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    prev_cmp_q |-> ((vcc_slice & ~prev_wen_q) == '0));

  assert_execz_from_sop_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(execz) |-> $past(sop_valid));

  assert_exec_hold_in_pass_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    pass_active |=> $stable(exec_mask));
endmodule

bind lane_mask_ctrl lmc_checker #(.LANES(LANES), .PASS_W(PASS_W), .IDX_W(IDX_W)) chk_i (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .pass_active (pass_active),
  .pass_idx    (pass_idx),
  .pass_last   (pass_last),
  .lane_wen    (lane_wen),
  .exec_mask   (exec_mask),
  .vcc_mask    (vcc_mask),
  .execz       (execz),
  .sop_valid   (sop_valid),
  .seq_is_cmp  (seq_is_cmp)
);

// File: tb/lane_mask_ctrl_tb_top.sv
`timescale 1ns/1ps
module lane_mask_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sop_valid;
  logic [1:0]  sop_kind;
  logic [2:0]  sop_sreg;
  logic        vec_start;
  logic        vec_is_cmp;
  logic [15:0] cmp_result;
  logic        br_valid;
  logic        br_kind;
  logic        br_taken;
  logic        pass_active;
  logic [1:0]  pass_idx;
  logic        pass_last;
  logic [15:0] lane_wen;
  logic [63:0] exec_mask;
  logic [63:0] vcc_mask;
  logic        execz;
  logic        vccz;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [63:0] m_exec;
  logic [63:0] m_vcc;
  logic [63:0] m_sreg [8];

  always #2 clk = ~clk;

  lane_mask_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sop_valid(sop_valid), .sop_kind(sop_kind),
    .sop_sreg(sop_sreg), .vec_start(vec_start), .vec_is_cmp(vec_is_cmp),
    .cmp_result(cmp_result), .br_valid(br_valid), .br_kind(br_kind),
    .br_taken(br_taken), .pass_active(pass_active), .pass_idx(pass_idx),
    .pass_last(pass_last), .lane_wen(lane_wen), .exec_mask(exec_mask),
    .vcc_mask(vcc_mask), .execz(execz), .vccz(vccz)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(int s);
    logic [63:0] x;
    if (s == 0) return 64'h0;
    if (s == 1) return '1;
    x = 64'(s) * 64'h9E3779B97F4A7C15;
    x = x ^ (x >> 31);
    x = x * 64'hBF58476D1CE4E5B9;
    return x ^ (x >> 27);
  endfunction

  task automatic do_sop(input logic [1:0] kind, input int idx);
    @(negedge clk);
    sop_valid = 1'b1; sop_kind = kind; sop_sreg = 3'(idx);
    case (kind)
      2'd0: m_sreg[idx] = m_exec;
      2'd1: m_exec = m_vcc & m_exec;
      2'd2: m_exec = m_sreg[idx] & ~m_exec;
      default: m_exec = m_sreg[idx];
    endcase
    @(negedge clk);
    sop_valid = 1'b0;
    case (kind)
      2'd0: chk("R2 save keeps exec", exec_mask, m_exec);
      2'd1: chk("R3 and-condition exec", exec_mask, m_exec);
      2'd2: chk("R4 and-not exec", exec_mask, m_exec);
      default: chk("R5 restore exec", exec_mask, m_exec);
    endcase
    chk("R9 execz flag", 64'(execz), 64'(m_exec == 64'h0));
  endtask

  task automatic chk_br(input logic kind);
    logic exp;
    br_valid = 1'b1; br_kind = kind;
    exp = kind ? (m_exec == 64'h0) : (m_vcc == 64'h0);
    #1;
    chk(kind ? "R9 br_taken execz" : "R9 br_taken vccz", 64'(br_taken), 64'(exp));
    br_valid = 1'b0;
  endtask

  task automatic do_vec(input bit cmp, input logic [63:0] res, input bit intrude);
    @(negedge clk);
    vec_start = 1'b1; vec_is_cmp = cmp;
    @(negedge clk);
    vec_start = 1'b0; vec_is_cmp = 1'b0;
    for (int p = 0; p < 4; p++) begin
      chk("R6 pass active", 64'(pass_active), 64'd1);
      chk("R6 pass index", 64'(pass_idx), 64'(p));
      chk("R6 pass last", 64'(pass_last), 64'(p == 3));
      chk("R7 lane write enables", 64'(lane_wen), 64'(m_exec[p*16 +: 16]));
      cmp_result = res[p*16 +: 16];
      if (cmp) m_vcc[p*16 +: 16] = res[p*16 +: 16] & m_exec[p*16 +: 16];
      if (intrude && p == 1) begin
        sop_valid = 1'b1; sop_kind = 2'd3; sop_sreg = 3'd6;
        vec_start = 1'b1; vec_is_cmp = ~cmp;
      end
      @(negedge clk);
      sop_valid = 1'b0; vec_start = 1'b0; vec_is_cmp = 1'b0;
      if (intrude && p == 1) chk("R10 exec unchanged by busy op", exec_mask, m_exec);
    end
    cmp_result = 16'h0;
    chk("R6 pass sequence ended", 64'(pass_active), 64'd0);
    chk("R7 idle write enables", 64'(lane_wen), 64'd0);
    chk(cmp ? "R8 compare vcc" : "R8 vcc kept", vcc_mask, m_vcc);
    chk("R9 vccz flag", 64'(vccz), 64'(m_vcc == 64'h0));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sop_valid = 1'b0; sop_kind = 2'd0; sop_sreg = 3'd0;
    vec_start = 1'b0; vec_is_cmp = 1'b0; cmp_result = 16'h0;
    br_valid = 1'b0; br_kind = 1'b0;
    m_exec = '1; m_vcc = '0;
    for (int i = 0; i < 8; i++) m_sreg[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 reset exec all ones", exec_mask, '1);
    chk("R1 reset vcc zero", vcc_mask, 64'h0);
    chk("R1 reset no pass", 64'(pass_active), 64'd0);
    chk("R1 reset wen zero", 64'(lane_wen), 64'd0);
    do_sop(2'd0, 7);
    do_sop(2'd3, 5);
    chk("R1 reset saved entry zero", exec_mask, 64'h0);
    chk_br(1'b1);
    do_sop(2'd3, 7);

    for (int s = 0; s < 48; s++) begin
      int k;
      k = s % 7;
      if (s % 6 == 5) do_sop(2'd3, 7);
      if (s % 3 == 2) begin
        do_vec(1'b1, pat(s + 100), 1'b0);
        do_sop(2'd1, 0);
      end
      do_vec(1'b1, pat(s), (s % 5) == 4);
      chk_br(1'b0);
      do_sop(2'd0, k);
      do_sop(2'd1, 0);
      chk_br(1'b1);
      do_vec(1'b0, pat(s + 7), 1'b0);
      do_sop(2'd2, k);
      chk_br(1'b1);
      do_vec(1'b0, pat(s + 9), (s % 4) == 1);
      do_sop(2'd3, k);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule